// File: doc/BRIEF.md
# Column Offset Calibration and Correction Unit

This block removes column-wise fixed-pattern offsets from a 12-bit pixel stream. It has two jobs that share one per-column store. In calibration, it sums every column over one complete dark frame. On the last line of that frame it turns each column sum into an 8-bit mean and keeps that mean as the column's coefficient. In correction, it subtracts the coefficient of the pixel's column from each pixel as the pixel passes. The result saturates at zero.

Pixels enter and leave on a valid/ready stream. Line and frame markers travel beside the input beat. The block has one output register. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new input is taken. Calibration is requested with a start pulse. The request counts only when the sensor is reading out at full resolution with no subsampling. Accumulation waits for the next frame start.

Top module: `fpn_column_unit`

## Requirements
- R1: After reset, `out_valid`, `cal_done`, `cal_overflow` and `cal_underflow` are low and `in_ready` is high.
- R2: When `corr_mode` is 2'b01 and a calibration has completed, each pixel inside a line leaves as pixel minus its column coefficient. When the coefficient is larger than the pixel, the result is 0; it never wraps.
- R3: When `corr_mode` is 2'b00, 2'b10 or 2'b11, pixels leave unchanged. Before any calibration has completed, mode 2'b01 also leaves pixels unchanged.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_pix` stays stable and `in_ready` is low. Each accepted beat appears on the output one cycle later.
- R5: The column index is 0 for the first accepted pixel after `in_lval` rises, and it rises by one with each accepted pixel. Pixels at index COLS or beyond pass unchanged and are not accumulated.
- R6: A `cal_start` pulse with `full_res` high arms calibration. Accumulation begins at the next rising edge of `in_fval`. A pulse with `full_res` low is ignored and changes neither the flags nor the coefficients.
- R7: Each coefficient equals the column sum over the 2^LINES_LOG2 lines, shifted right by LINES_LOG2 and clamped to 255.
- R8: `cal_done` is high for exactly one cycle, the cycle after `in_fval` is first sampled low, when the frame held at least 2^LINES_LOG2 lines. A shorter frame gives no `cal_done`, leaves the coefficients unchanged and keeps the block armed for the next frame.
- R9: During accumulation, a pixel above 255 sets `cal_overflow` and a pixel of 0 sets `cal_underflow`. Both flags are sticky. An accepted arming request clears them, and pixels seen outside accumulation never set them.
- R10: Lines after the first 2^LINES_LOG2 lines of a calibration frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| in_pix | input | PIX_W | Input pixel |
| in_lval | input | 1 | Line active marker for the input beat |
| in_fval | input | 1 | Frame active marker |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pix | output | PIX_W | Corrected pixel |
| corr_mode | input | 2 | 00 off, 01 stored-offset correction, 10 and 11 pass |
| full_res | input | 1 | Sensor is at full resolution, no subsampling |
| cal_start | input | 1 | Calibration arm request |
| cal_done | output | 1 | One-cycle pulse when a calibration frame completes |
| cal_overflow | output | 1 | Sticky: a dark pixel above 255 was seen |
| cal_underflow | output | 1 | Sticky: a dark pixel of 0 was seen |

## Verification
The checks assume that `in_fval` rises at least one cycle before the first `in_lval` of a frame. They also assume that `in_fval` falls at least one cycle after the last `in_lval`, so that the frame-end decision counts every line end. Input beats are assumed only while `in_lval` is high, and `out_ready` may drop at any time. The stimulus follows all of these assumptions: it raises and lowers the frame marker with idle cycles on both sides of the lines, and it holds the line marker high for every pixel it offers.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef enum logic [1:0] {
    CORR_OFF     = 2'b00,
    CORR_STORED  = 2'b01,
    CORR_RSVD    = 2'b10,
    CORR_MASKED  = 2'b11
  } corr_mode_e;

  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_ARMED = 2'd1,
    CAL_ACCUM = 2'd2
  } cal_state_e;

endpackage

// File: rtl/fpn_line_tracker.sv
module fpn_line_tracker #(
  parameter int COLS = 1312,
  localparam int CW = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lval,
  input  logic          fval,
  input  logic          beat,
  output logic [CW-1:0] col,
  output logic          col_in_range,
  output logic          fval_rise,
  output logic          line_end
);

  logic lval_q, fval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lval_q <= 1'b0;
      fval_q <= 1'b0;
      col    <= '0;
    end else begin
      lval_q <= lval;
      fval_q <= fval;
      if (!lval)
        col <= '0;
      else if (beat && col_in_range)
        col <= col + 1'b1;
    end
  end

  assign col_in_range = (col < CW'(COLS));
  assign fval_rise    = fval && !fval_q;
  assign line_end     = lval_q && !lval;

  assert_col_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col <= CW'(COLS));

  assert_col_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lval |=> (col == '0));

endmodule

// File: rtl/fpn_cal_ctrl.sv
module fpn_cal_ctrl
  import fpn_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int LINES_LOG2 = 10,
  localparam int LINES = 1 << LINES_LOG2,
  localparam int LCW   = LINES_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             full_res,
  input  logic             fval,
  input  logic             lval,
  input  logic             fval_rise,
  input  logic             line_end,
  input  logic             beat,
  input  logic             col_in_range,
  input  logic [PIX_W-1:0] pix,
  output logic             acc_en,
  output logic             first_line,
  output logic             last_line,
  output logic             coef_ok,
  output logic             cal_done,
  output logic             ovf,
  output logic             unf
);

  cal_state_e     state;
  logic [LCW-1:0] line_cnt;
  logic           arm_req;

  assign arm_req    = start && full_res;
  assign acc_en     = (state == CAL_ACCUM) && fval && lval && beat &&
                      col_in_range && (line_cnt < LCW'(LINES));
  assign first_line = (line_cnt == '0);
  assign last_line  = (line_cnt == LCW'(LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CAL_IDLE;
      line_cnt <= '0;
      coef_ok  <= 1'b0;
      cal_done <= 1'b0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      cal_done <= 1'b0;
      if (arm_req) begin
        state    <= CAL_ARMED;
        line_cnt <= '0;
        ovf      <= 1'b0;
        unf      <= 1'b0;
      end else begin
        unique case (state)
          CAL_ARMED: begin
            if (fval_rise) begin
              state    <= CAL_ACCUM;
              line_cnt <= '0;
            end
          end
          CAL_ACCUM: begin
            if (!fval) begin
              line_cnt <= '0;
              if (line_cnt == LCW'(LINES)) begin
                state    <= CAL_IDLE;
                cal_done <= 1'b1;
                coef_ok  <= 1'b1;
              end else begin
                state <= CAL_ARMED;
              end
            end else if (line_end && (line_cnt < LCW'(LINES))) begin
              line_cnt <= line_cnt + 1'b1;
            end
          end
          default: ;
        endcase
        if (acc_en && (pix > PIX_W'(255))) ovf <= 1'b1;
        if (acc_en && (pix == '0))         unf <= 1'b1;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !arm_req) |=> ovf);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !arm_req) |=> unf);

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm_req |=> (!ovf && !unf));

  assert_line_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= LCW'(LINES));

  assert_accum_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAL_IDLE) |-> !acc_en);

endmodule

// File: rtl/fpn_col_store.sv
module fpn_col_store #(
  parameter int COLS       = 1312,
  parameter int PIX_W      = 12,
  parameter int COEF_W     = 8,
  parameter int LINES_LOG2 = 10,
  localparam int IW    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SUM_W = PIX_W + LINES_LOG2
) (
  input  logic              clk,
  input  logic [IW-1:0]     idx,
  input  logic              acc_en,
  input  logic              first_line,
  input  logic              last_line,
  input  logic [PIX_W-1:0]  pix,
  output logic [COEF_W-1:0] coef
);

  localparam logic [SUM_W-1:0] COEF_MAX = SUM_W'((1 << COEF_W) - 1);

  logic [SUM_W-1:0]  sum_mem  [COLS];
  logic [COEF_W-1:0] coef_mem [COLS];

  logic [SUM_W-1:0]  pix_ext, acc, mean;
  logic [COEF_W-1:0] mean_clamped;

  assign pix_ext = {{LINES_LOG2{1'b0}}, pix};
  assign acc     = first_line ? pix_ext : (sum_mem[idx] + pix_ext);
  assign mean    = acc >> LINES_LOG2;
  assign mean_clamped = (mean > COEF_MAX) ? {COEF_W{1'b1}} : mean[COEF_W-1:0];

  always_ff @(posedge clk) begin
    if (acc_en) begin
      sum_mem[idx] <= acc;
      if (last_line)
        coef_mem[idx] <= mean_clamped;
    end
  end

  assign coef = coef_mem[idx];

endmodule

// File: rtl/fpn_correct_stage.sv
module fpn_correct_stage #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              apply,
  input  logic [COEF_W-1:0] coef,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix
);

  logic [PIX_W-1:0] coef_ext, result;

  assign coef_ext = {{(PIX_W-COEF_W){1'b0}}, coef};
  assign result   = !apply               ? in_pix :
                    (in_pix >= coef_ext) ? (in_pix - coef_ext) : '0;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_pix <= result;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_pix <= $past(in_pix)));

endmodule

// File: rtl/fpn_column_unit.sv
module fpn_column_unit
  import fpn_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int COEF_W     = 8,
  parameter int COLS       = 1312,
  parameter int LINES_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_lval,
  input  logic             in_fval,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  input  logic [1:0]       corr_mode,
  input  logic             full_res,
  input  logic             cal_start,
  output logic             cal_done,
  output logic             cal_overflow,
  output logic             cal_underflow
);

  localparam int CW = $clog2(COLS + 1);
  localparam int IW = (COLS > 1) ? $clog2(COLS) : 1;

  logic              beat, col_in_range, fval_rise, line_end;
  logic [CW-1:0]     col;
  logic              acc_en, first_line, last_line, coef_ok, apply;
  logic [COEF_W-1:0] coef;

  assign beat  = in_valid && in_ready && in_lval;
  assign apply = (corr_mode_e'(corr_mode) == CORR_STORED) && in_lval &&
                 col_in_range && coef_ok;

  fpn_line_tracker #(.COLS(COLS)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .lval         (in_lval),
    .fval         (in_fval),
    .beat         (beat),
    .col          (col),
    .col_in_range (col_in_range),
    .fval_rise    (fval_rise),
    .line_end     (line_end)
  );

  fpn_cal_ctrl #(.PIX_W(PIX_W), .LINES_LOG2(LINES_LOG2)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (cal_start),
    .full_res     (full_res),
    .fval         (in_fval),
    .lval         (in_lval),
    .fval_rise    (fval_rise),
    .line_end     (line_end),
    .beat         (beat),
    .col_in_range (col_in_range),
    .pix          (in_pix),
    .acc_en       (acc_en),
    .first_line   (first_line),
    .last_line    (last_line),
    .coef_ok      (coef_ok),
    .cal_done     (cal_done),
    .ovf          (cal_overflow),
    .unf          (cal_underflow)
  );

  fpn_col_store #(
    .COLS(COLS), .PIX_W(PIX_W), .COEF_W(COEF_W), .LINES_LOG2(LINES_LOG2)
  ) u_store (
    .clk        (clk),
    .idx        (col[IW-1:0]),
    .acc_en     (acc_en),
    .first_line (first_line),
    .last_line  (last_line),
    .pix        (in_pix),
    .coef       (coef)
  );

  fpn_correct_stage #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pix    (in_pix),
    .apply     (apply),
    .coef      (coef),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
  );

  assert_pass_modes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (corr_mode != 2'b01)) |=> (out_pix == $past(in_pix)));

endmodule

// File: tb/tb_fpn_column_unit.sv
module tb_fpn_column_unit;

  localparam int PW = 12;
  localparam int NC = 4;
  localparam int LL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_lval = 1'b0, in_fval = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic          out_ready = 1'b1;
  logic [1:0]    corr_mode = 2'b00;
  logic          full_res = 1'b1, cal_start = 1'b0;
  logic          in_ready, out_valid, cal_done, cal_overflow, cal_underflow;
  logic [PW-1:0] out_pix;

  int tests = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fpn_column_unit #(.PIX_W(PW), .COEF_W(8), .COLS(NC), .LINES_LOG2(LL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_lval(in_lval), .in_fval(in_fval),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .corr_mode(corr_mode), .full_res(full_res), .cal_start(cal_start),
    .cal_done(cal_done), .cal_overflow(cal_overflow), .cal_underflow(cal_underflow)
  );

  always @(negedge clk) if (rst_n && cal_done) done_cnt++;

  typedef struct packed {
    logic [1:0]          mode;
    logic [0:3][PW-1:0]  pix;
    logic [0:3][PW-1:0]  exp;
  } vec_t;

  // Coefficients after the first calibration: 20, 2, 255, 255
  localparam vec_t VECS [6] = '{
    '{mode: 2'b01, pix: '{12'd100, 12'd1, 12'd255, 12'd4095}, exp: '{12'd80, 12'd0, 12'd0, 12'd3840}},
    '{mode: 2'b01, pix: '{12'd20,  12'd2, 12'd300, 12'd255},  exp: '{12'd0,  12'd0, 12'd45, 12'd0}},
    '{mode: 2'b01, pix: '{12'd21,  12'd3, 12'd256, 12'd254},  exp: '{12'd1,  12'd1, 12'd1,  12'd0}},
    '{mode: 2'b00, pix: '{12'd100, 12'd1, 12'd255, 12'd4095}, exp: '{12'd100, 12'd1, 12'd255, 12'd4095}},
    '{mode: 2'b10, pix: '{12'd100, 12'd1, 12'd255, 12'd4095}, exp: '{12'd100, 12'd1, 12'd255, 12'd4095}},
    '{mode: 2'b11, pix: '{12'd100, 12'd1, 12'd255, 12'd4095}, exp: '{12'd100, 12'd1, 12'd255, 12'd4095}}
  };

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [PW-1:0] p, input bit chk, input int exp, input string tag);
    @(negedge clk);
    in_lval  = 1'b1;
    in_valid = 1'b1;
    in_pix   = p;
    @(negedge clk);
    in_valid = 1'b0;
    if (chk) begin
      check({tag, " valid"}, int'(out_valid), 1);
      check(tag, int'(out_pix), exp);
    end
  endtask

  task automatic end_line();
    @(negedge clk);
    in_lval = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
  endtask

  // kind 0: all zero; kind 1: first calibration; kind 2: second calibration
  function automatic logic [PW-1:0] cal_pix(input int kind, input int ln, input int c);
    if (kind == 0) return '0;
    if (kind == 1) begin
      case (c)
        0: return 12'd20;
        1: return PW'(ln + 1);
        2: return 12'd255;
        default: return 12'd300;
      endcase
    end
    if (ln >= 4) return 12'd4000;
    case (c)
      0: return 12'd40;
      1: return 12'd0;
      2: return 12'd8;
      default: return 12'd400;
    endcase
  endfunction

  task automatic send_frame(input int kind, input int nlines);
    @(negedge clk);
    in_fval = 1'b1;
    @(negedge clk);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int c = 0; c < NC; c++) push(cal_pix(kind, ln, c), 1'b0, 0, "");
      end_line();
    end
    @(negedge clk);
    in_fval = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic line4(input logic [1:0] m, input logic [0:3][PW-1:0] p,
                       input logic [0:3][PW-1:0] e, input string tag);
    corr_mode = m;
    for (int c = 0; c < NC; c++) push(p[c], 1'b1, int'(e[c]), tag);
    end_line();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 done", int'(cal_done), 0);
    check("R1 overflow", int'(cal_overflow), 0);
    check("R1 underflow", int'(cal_underflow), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: no calibration yet, mode 01 passes; R9: flags untouched outside accumulation
    line4(2'b01, '{12'd50, 12'd0, 12'd4095, 12'd7}, '{12'd50, 12'd0, 12'd4095, 12'd7}, "R3 uncalibrated");
    check("R9 no flag outside accum ovf", int'(cal_overflow), 0);
    check("R9 no flag outside accum unf", int'(cal_underflow), 0);

    // R6: request with full_res low is ignored
    full_res = 1'b0;
    arm();
    full_res = 1'b1;
    send_frame(0, 4);
    check("R6 ignored no done", done_cnt, 0);
    check("R6 ignored unf", int'(cal_underflow), 0);
    line4(2'b01, '{12'd50, 12'd60, 12'd70, 12'd80}, '{12'd50, 12'd60, 12'd70, 12'd80}, "R6 ignored coefs");

    // R6/R7/R8/R9: first calibration
    arm();
    send_frame(1, 4);
    check("R8 one done pulse", done_cnt, 1);
    check("R9 overflow set", int'(cal_overflow), 1);
    check("R9 underflow clear", int'(cal_underflow), 0);

    // R2/R3/R7 table walk
    foreach (VECS[i]) line4(VECS[i].mode, VECS[i].pix, VECS[i].exp, "R2 R3 R7 table");

    // R5: columns beyond COLS pass unchanged, index restarts each line
    corr_mode = 2'b01;
    push(12'd100, 1'b1, 80, "R5 col0");
    push(12'd1, 1'b1, 0, "R5 col1");
    push(12'd255, 1'b1, 0, "R5 col2");
    push(12'd4095, 1'b1, 3840, "R5 col3");
    push(12'd77, 1'b1, 77, "R5 col4 beyond");
    push(12'd88, 1'b1, 88, "R5 col5 beyond");
    end_line();
    push(12'd25, 1'b1, 5, "R5 restart col0");
    end_line();

    // R4: back-pressure
    corr_mode = 2'b00;
    out_ready = 1'b0;
    @(negedge clk);
    in_lval = 1'b1; in_valid = 1'b1; in_pix = 12'd100;
    @(negedge clk);
    in_pix = 12'd200;
    check("R4 valid held", int'(out_valid), 1);
    check("R4 in_ready low", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    check("R4 data stable", int'(out_pix), 100);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 next word", int'(out_pix), 200);
    @(negedge clk);
    check("R4 drained", int'(out_valid), 0);
    end_line();

    // R8: short frame gives no done, coefs unchanged; R9 arm clears flags
    arm();
    check("R9 arm clears ovf", int'(cal_overflow), 0);
    send_frame(0, 2);
    check("R8 short frame no done", done_cnt, 1);
    check("R9 underflow set", int'(cal_underflow), 1);
    line4(2'b01, '{12'd100, 12'd1, 12'd255, 12'd4095}, '{12'd80, 12'd0, 12'd0, 12'd3840}, "R8 coefs kept");

    // R8/R10: still armed; a five-line frame uses only the first four lines
    send_frame(2, 5);
    check("R8 done after rearm", done_cnt, 2);
    check("R9 ovf second", int'(cal_overflow), 1);
    line4(2'b01, '{12'd100, 12'd5, 12'd8, 12'd300}, '{12'd60, 12'd5, 12'd0, 12'd45}, "R10 R7 second coefs");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule